// File: doc/BRIEF.md
# Priority Program Scheduler

This block decides which of sixteen resident programs owns the processor. Each program has one pending flag. The flag of program 0, which has the highest priority, is raised only by an unexpected arithmetic overflow. Fourteen peripheral demand lines raise the flags of programs 1 to 14. A running instruction can raise the flag of any program from 1 to 15. Only the program that owns a flag can lower it. It does so with the instruction's self-clear bit, and a program whose flag is low stays dormant.

At every instruction boundary the sequencer compares the most urgent pending flag with the running program. A lower number means a higher priority. If the two match, the running program continues. If they differ, the block raises a fetch request and drives the executive-space address of the winner's saved program counter. That address is a base plus eight times the program number. Within each eight-word slot, offset 0 holds the program counter, offsets 1 to 6 hold the index registers and offset 7 holds a work word. While that fetch is outstanding, a more urgent flag redirects it. When no flag is pending, the block rests in an idle state and keeps the last program number.

The sequencer has three states:
- `ST_IDLE`: reached from reset, and from `ST_RUN` when no flag is pending at a boundary.
- `ST_FETCH`: reached from `ST_IDLE` when any flag becomes pending, and from `ST_RUN` when the boundary winner differs from the running program. It retargets itself when a more urgent flag appears.
- `ST_RUN`: reached from `ST_FETCH` on `fetch_done`.

Top module: `psched_top`

## Requirements
- R1: After reset, all sixteen flags are clear, `idle` is 1, `irq_req` is 0 and `active_prog` is 0.
- R2: A high `ovf_alarm` sets flag 0. `ext_demand[j]` sets flag j+1. `sw_set` sets flag `sw_idx`, except that a software set of index 0 is ignored. Each set is visible on `pend_flags` one cycle later.
- R3: In `ST_RUN`, `suicide` clears only the flag of `active_prog`. It has no effect in `ST_IDLE` or `ST_FETCH`.
- R4: When a set and a clear hit the same flag in the same cycle, the flag stays set.
- R5: In `ST_RUN`, a `boundary` whose most urgent pending flag is the running program's own leaves the block in `ST_RUN`, with `irq_req` at 0 and `active_prog` unchanged.
- R6: In `ST_RUN`, a `boundary` whose most urgent pending flag w differs from `active_prog` gives `irq_req`=1 one cycle later, with `pc_addr` = `EXEC_BASE` + 8·w. Events that arrive in the boundary cycle take part in this decision.
- R7: Flags of lower priority than the running program do not preempt it. They stay pending.
- R8: In `ST_FETCH`, a newly pending flag more urgent than the target moves `pc_addr` to that flag's slot one cycle later. A retarget takes precedence over a simultaneous `fetch_done`. A less urgent flag and `boundary` do not change the target.
- R9: In `ST_FETCH`, `fetch_done` without a retarget makes the target the `active_prog` and lowers `irq_req` one cycle later.
- R10: A boundary with no flag pending moves the block to `ST_IDLE` (`idle`=1) and keeps `active_prog`. From `ST_IDLE`, any newly pending flag starts a fetch one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_alarm | input | 1 | Unexpected overflow; sets flag 0 |
| ext_demand | input | NDEM | Peripheral demands; bit j sets flag j+1 |
| sw_set | input | 1 | Instruction sets the flag selected by sw_idx |
| sw_idx | input | IW | Program number for sw_set |
| suicide | input | 1 | Running instruction clears its own program's flag |
| boundary | input | 1 | Instruction boundary; scheduling check |
| fetch_done | input | 1 | Saved program counter has been fetched |
| irq_req | output | 1 | Fetch of a program counter requested (ST_FETCH) |
| pc_addr | output | AW | Executive-space address of the target's saved program counter |
| active_prog | output | IW | Running program number |
| idle | output | 1 | No program pending (ST_IDLE) |
| pend_flags | output | NPROG | Pending flag register |

## Verification
Every result is due exactly one clock edge after its stimulus. This holds for a flag set or clear, a state change and a new `pc_addr`, because the flag register and the sequencer both decide on the same cycle's next flag value. The bench drives each stimulus just after a falling edge and holds it for one rising edge. It then reads the ports at the following falling edge, so every comparison lands on the cycle in which the result is due. Preemption is swept over every ordered pair of running and arriving programs, starting from a fresh reset each time. The expected winner and slot address are computed from the two numbers alone.

// File: rtl/psched_pkg.sv
package psched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2
    } sched_state_e;
endpackage

// File: rtl/psched_flags.sv
module psched_flags #(
    parameter int NPROG = 16,
    parameter int NDEM  = 14,
    parameter int IW    = $clog2(NPROG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_alarm,
    input  logic [NDEM-1:0]  ext_demand,
    input  logic             sw_set,
    input  logic [IW-1:0]    sw_idx,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [NPROG-1:0] flags_q,
    output logic [NPROG-1:0] flags_d
);
    logic [NPROG-1:0] set_vec;
    logic [NPROG-1:0] clr_vec;

    for (genvar i = 0; i < NPROG; i++) begin : g_bit
        if (i == 0) begin : g_top
            // most urgent flag: overflow only
            assign set_vec[i] = ovf_alarm;
        end else if (i <= NDEM) begin : g_dem
            assign set_vec[i] = ext_demand[i-1] | (sw_set && (sw_idx == IW'(i)));
        end else begin : g_sw
            assign set_vec[i] = sw_set && (sw_idx == IW'(i));
        end
        assign clr_vec[i] = clr_en && (clr_idx == IW'(i));
    end

    // a set overrides a clear of the same flag
    assign flags_d = (flags_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/psched_enc.sv
module psched_enc #(
    parameter int NPROG = 16,
    parameter int IW    = $clog2(NPROG)
) (
    input  logic [NPROG-1:0] vec,
    output logic             any,
    output logic [IW-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = NPROG - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/psched_fsm.sv
module psched_fsm
    import psched_pkg::*;
#(
    parameter int             NPROG     = 16,
    parameter int             AW        = 14,
    parameter int             IW        = $clog2(NPROG),
    parameter logic [AW-1:0]  EXEC_BASE = 14'h3F80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          fetch_done,
    input  logic          suicide,
    input  logic          win_any,
    input  logic [IW-1:0] win_idx,
    output logic          clr_en,
    output logic          irq_req,
    output logic          idle,
    output logic [AW-1:0] pc_addr,
    output logic [IW-1:0] active_prog
);
    localparam int SLOT_SH = 3;

    sched_state_e  state_q, state_n;
    logic [IW-1:0] active_q, active_n;
    logic [IW-1:0] target_q, target_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            active_q <= '0;
            target_q <= '0;
        end else begin
            state_q  <= state_n;
            active_q <= active_n;
            target_q <= target_n;
        end
    end

    always_comb begin
        state_n  = state_q;
        active_n = active_q;
        target_n = target_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) begin
                    state_n  = ST_FETCH;
                    target_n = win_idx;
                end
            end
            ST_RUN: begin
                if (boundary) begin
                    if (!win_any) begin
                        state_n = ST_IDLE;
                    end else if (win_idx != active_q) begin
                        state_n  = ST_FETCH;
                        target_n = win_idx;
                    end
                end
            end
            ST_FETCH: begin
                if (win_any && (win_idx < target_q)) begin
                    target_n = win_idx;
                end else if (fetch_done) begin
                    state_n  = ST_RUN;
                    active_n = target_q;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req     = (state_q == ST_FETCH);
        idle        = (state_q == ST_IDLE);
        clr_en      = suicide && (state_q == ST_RUN);
        pc_addr     = EXEC_BASE + (AW'(target_q) << SLOT_SH);
        active_prog = active_q;
    end
endmodule

// File: rtl/psched_top.sv
module psched_top #(
    parameter int             NPROG     = 16,
    parameter int             NDEM      = 14,
    parameter int             AW        = 14,
    parameter int             IW        = $clog2(NPROG),
    parameter logic [AW-1:0]  EXEC_BASE = 14'h3F80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_alarm,
    input  logic [NDEM-1:0]  ext_demand,
    input  logic             sw_set,
    input  logic [IW-1:0]    sw_idx,
    input  logic             suicide,
    input  logic             boundary,
    input  logic             fetch_done,
    output logic             irq_req,
    output logic [AW-1:0]    pc_addr,
    output logic [IW-1:0]    active_prog,
    output logic             idle,
    output logic [NPROG-1:0] pend_flags
);
    logic [NPROG-1:0] flags_d;
    logic             clr_en;
    logic             win_any;
    logic [IW-1:0]    win_idx;

    psched_flags #(.NPROG(NPROG), .NDEM(NDEM), .IW(IW)) u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_alarm(ovf_alarm), .ext_demand(ext_demand),
        .sw_set(sw_set), .sw_idx(sw_idx), .clr_en(clr_en), .clr_idx(active_prog),
        .flags_q(pend_flags), .flags_d(flags_d)
    );

    psched_enc #(.NPROG(NPROG), .IW(IW)) u_enc (
        .vec(flags_d), .any(win_any), .idx(win_idx)
    );

    psched_fsm #(.NPROG(NPROG), .AW(AW), .IW(IW), .EXEC_BASE(EXEC_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .fetch_done(fetch_done),
        .suicide(suicide), .win_any(win_any), .win_idx(win_idx), .clr_en(clr_en),
        .irq_req(irq_req), .idle(idle), .pc_addr(pc_addr), .active_prog(active_prog)
    );
endmodule

// File: rtl/psched_chk.sv
module psched_chk #(
    parameter int             NPROG     = 16,
    parameter int             NDEM      = 14,
    parameter int             AW        = 14,
    parameter int             IW        = $clog2(NPROG),
    parameter logic [AW-1:0]  EXEC_BASE = 14'h3F80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovf_alarm,
    input logic [NDEM-1:0]  ext_demand,
    input logic             sw_set,
    input logic [IW-1:0]    sw_idx,
    input logic             suicide,
    input logic             fetch_done,
    input logic             irq_req,
    input logic [AW-1:0]    pc_addr,
    input logic [IW-1:0]    active_prog,
    input logic             idle,
    input logic [NPROG-1:0] pend_flags
);
    localparam logic [NPROG-1:0] ONE = {{(NPROG-1){1'b0}}, 1'b1};
    logic [IW-1:0] tgt_idx;
    assign tgt_idx = IW'((pc_addr - EXEC_BASE) >> 3);

    // R2
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_alarm |=> pend_flags[0]);

    // R2
    demand_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_demand) |=> ((pend_flags[NDEM:1] & $past(ext_demand)) == $past(ext_demand)));

    // R2
    sw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && (sw_idx != '0)) |=> pend_flags[$past(sw_idx)]);

    // R3
    owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_flags) & ~pend_flags)) |->
            ($past(suicide) && !$past(irq_req) && !$past(idle) &&
             (($past(pend_flags) & ~pend_flags) == (ONE << $past(active_prog)))));

    // R10
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (pend_flags == '0));

    // R6
    slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pc_addr[2:0] == 3'b000) && (pc_addr >= EXEC_BASE)));

    // R8
    target_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend_flags[tgt_idx]);

    // R9
    active_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_prog) |-> ($past(irq_req) && $past(fetch_done)));
endmodule

bind psched_top psched_chk #(
    .NPROG(NPROG), .NDEM(NDEM), .AW(AW), .IW(IW), .EXEC_BASE(EXEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ovf_alarm(ovf_alarm), .ext_demand(ext_demand),
    .sw_set(sw_set), .sw_idx(sw_idx), .suicide(suicide), .fetch_done(fetch_done),
    .irq_req(irq_req), .pc_addr(pc_addr), .active_prog(active_prog), .idle(idle),
    .pend_flags(pend_flags)
);

// File: tb/psched_top_test.sv
`timescale 1ns/1ps
module psched_top_test;
    localparam int NPROG = 16;
    localparam int NDEM  = 14;
    localparam int AW    = 14;
    localparam int IW    = 4;
    localparam int BASE  = 14'h3F80;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ovf_alarm;
    logic [NDEM-1:0]  ext_demand;
    logic             sw_set;
    logic [IW-1:0]    sw_idx;
    logic             suicide;
    logic             boundary;
    logic             fetch_done;
    logic             irq_req;
    logic [AW-1:0]    pc_addr;
    logic [IW-1:0]    active_prog;
    logic             idle;
    logic [NPROG-1:0] pend_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    psched_top uut (
        .clk(clk), .rst_n(rst_n), .ovf_alarm(ovf_alarm), .ext_demand(ext_demand),
        .sw_set(sw_set), .sw_idx(sw_idx), .suicide(suicide), .boundary(boundary),
        .fetch_done(fetch_done), .irq_req(irq_req), .pc_addr(pc_addr),
        .active_prog(active_prog), .idle(idle), .pend_flags(pend_flags)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        ovf_alarm = 0; ext_demand = '0; sw_set = 0; sw_idx = '0;
        suicide = 0; boundary = 0; fetch_done = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    function automatic int slot(input int p);
        return BASE + 8 * p;
    endfunction

    // start program p (1..15) from idle and let it run
    task automatic launch(input int p);
        sw_set = 1; sw_idx = IW'(p);
        tick();
        fetch_done = 1;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_in();
        do_reset();
        // R1 reset state
        chk("R1", "pend", int'(pend_flags), 0);
        chk("R1", "idle", int'(idle), 1);
        chk("R1", "irq", int'(irq_req), 0);
        chk("R1", "active", int'(active_prog), 0);

        // software set sweep, full lifecycle per program
        for (int i = 0; i < NPROG; i++) begin
            do_reset();
            sw_set = 1; sw_idx = IW'(i);
            tick();
            if (i == 0) begin
                // R2 software set of flag 0 ignored
                chk("R2", "sw0 pend", int'(pend_flags), 0);
                chk("R2", "sw0 idle", int'(idle), 1);
            end else begin
                chk("R2", "sw pend", int'(pend_flags), 1 << i);
                chk("R10", "idle->fetch irq", int'(irq_req), 1);
                chk("R6", "slot addr", int'(pc_addr), slot(i));
                fetch_done = 1;
                tick();
                chk("R9", "active", int'(active_prog), i);
                chk("R9", "irq low", int'(irq_req), 0);
                boundary = 1;
                tick();
                chk("R5", "own flag stays", int'(irq_req), 0);
                chk("R5", "not idle", int'(idle), 0);
                suicide = 1; boundary = 1;
                tick();
                chk("R3", "cleared", int'(pend_flags), 0);
                chk("R10", "idle", int'(idle), 1);
                chk("R10", "active kept", int'(active_prog), i);
            end
        end

        // demand line sweep and overflow
        for (int j = 0; j <= NDEM; j++) begin
            int p;
            p = (j == NDEM) ? 0 : j + 1;
            do_reset();
            if (j == NDEM) ovf_alarm = 1;
            else ext_demand[j] = 1'b1;
            tick();
            chk("R2", "demand pend", int'(pend_flags), 1 << p);
            chk("R6", "demand addr", int'(pc_addr), slot(p));
            fetch_done = 1;
            tick();
            chk("R9", "demand active", int'(active_prog), p);
        end

        // preemption over every running/arriving pair
        for (int a = 1; a < NPROG; a++) begin
            for (int b = 0; b < NPROG; b++) begin
                if (b != a) begin
                    do_reset();
                    launch(a);
                    if (b == 0) ovf_alarm = 1;
                    else begin sw_set = 1; sw_idx = IW'(b); end
                    boundary = 1;
                    tick();
                    chk("R7", "both pending", int'(pend_flags), (1 << a) | (1 << b));
                    if (b < a) begin
                        chk("R6", "preempt irq", int'(irq_req), 1);
                        chk("R6", "preempt addr", int'(pc_addr), slot(b));
                        fetch_done = 1;
                        tick();
                        chk("R9", "preempt active", int'(active_prog), b);
                    end else begin
                        chk("R7", "no preempt", int'(irq_req), 0);
                        chk("R7", "still active", int'(active_prog), a);
                    end
                end
            end
        end

        // R4 set wins over same-cycle clear (software and demand)
        do_reset();
        launch(4);
        suicide = 1; sw_set = 1; sw_idx = 4'd4; boundary = 1;
        tick();
        chk("R4", "sw set wins", int'(pend_flags[4]), 1);
        chk("R4", "still running", int'(irq_req | idle), 0);
        do_reset();
        launch(6);
        suicide = 1; ext_demand[5] = 1'b1; boundary = 1;
        tick();
        chk("R4", "demand set wins", int'(pend_flags[6]), 1);
        chk("R4", "active kept", int'(active_prog), 6);

        // R8 retarget during fetch, R3 suicide ignored during fetch
        do_reset();
        sw_set = 1; sw_idx = 4'd9;
        tick();
        chk("R8", "fetch 9", int'(pc_addr), slot(9));
        ext_demand[11] = 1'b1; boundary = 1;
        tick();
        chk("R8", "lower no retarget", int'(pc_addr), slot(9));
        suicide = 1;
        tick();
        chk("R3", "suicide ignored in fetch", int'(pend_flags), (1 << 9) | (1 << 12));
        ext_demand[2] = 1'b1; fetch_done = 1;
        tick();
        chk("R8", "retarget addr", int'(pc_addr), slot(3));
        chk("R8", "retarget beats done", int'(irq_req), 1);
        chk("R8", "active unchanged", int'(active_prog), 0);
        fetch_done = 1;
        tick();
        chk("R9", "active 3", int'(active_prog), 3);
        suicide = 1; boundary = 1;
        tick();
        chk("R3", "only own cleared", int'(pend_flags), (1 << 9) | (1 << 12));
        chk("R6", "next winner", int'(pc_addr), slot(9));
        chk("R6", "next irq", int'(irq_req), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule